// File: doc/BRIEF.md
# Low-speed USB packet response controller

This block sits between a low-speed USB packet receiver and the matching transmitter. At the end of every received packet the receiver presents the PID, the byte that follows it and the packet length for one cycle. The controller decides how to answer and registers that decision on the next clock edge. It either tells the transmitter to send a handshake (ACK or NAK) or the data packet already prepared in the transmit buffer, or it stays silent.

The controller keeps the state that links packets together. It remembers the last SETUP or OUT token aimed at this device, so it can accept only the data that follows such a token. It keeps a full flag for the receive side, which has two buffers used in turn. It keeps a full flag for the single transmit buffer. It holds the device address, and a requested new address takes effect only once the current transfer is complete. A single-ended-zero detector finds bus resets and clears the buffer flags and the requested address.

The firmware side uses the controller through a few pulses: it frees the receive buffer, loads the transmit buffer, requests an address, and raises a busy level while a multi-packet transfer is still in progress.

Top module: `usbtk_ctrl`

## Requirements
- R1: After reset the controller gives no reply. `rx_full`, `tx_full`, `rx_sel` and `bus_reset` read 0, and `dev_addr` reads 0.
- R2: Every reply appears on `reply_valid` exactly one cycle after the `pkt_valid` cycle that caused it, and never at any other time. `reply_kind` is encoded 1 = ACK, 2 = NAK, 3 = data packet. `reply_pid` carries 0xD2 for ACK, 0x5A for NAK and 0x00 for a data reply.
- R3: A packet shorter than 3 bytes (PID plus two bytes) gets no reply, changes no buffer flag and clears the stored token.
- R4: A SETUP (0x2D) or OUT (0xE1) token whose address matches gets no reply and becomes the stored token.
- R5: For every PID other than DATA0/DATA1, the low 7 bits of `pkt_addr` are compared with `dev_addr`, and bit 7 is not compared. A mismatch, or a matching packet with a PID other than SETUP, OUT or IN, gets no reply, leaves the buffer flags and `rx_sel` unchanged, and clears the stored token.
- R6: A DATA0 (0xC3) or DATA1 (0x4B) packet that arrives while no token is stored gets no reply and leaves the receive state unchanged.
- R7: A DATA packet that follows a stored token while `rx_full` is 1 gets a NAK, and `rx_len`, `rx_token` and `rx_sel` keep their values.
- R8: A DATA packet that follows a stored token while `rx_full` is 0 is accepted and gets an ACK, with no address check. On acceptance `rx_full` becomes 1, `rx_len` takes the packet length, `rx_token` takes the stored token PID, and `rx_sel` toggles.
- R9: An IN (0x69) token for this device gets a NAK when `tx_full` is 0 or `rx_full` is 1. Otherwise it gets a data reply, and `tx_full` returns to 0.
- R10: `rx_release` clears `rx_full` and `tx_load` sets `tx_full`. When `tx_load` arrives in the same cycle as an IN that is being answered with data, `tx_full` stays 1.
- R11: `addr_set` records `addr_new` as the pending address. `dev_addr` copies the pending address only in cycles where `tx_full` and `xfer_busy` are both 0.
- R12: When `se0` is high for `SE0_CYCLES` consecutive cycles, a one-cycle `bus_reset` pulse follows. It clears `rx_full`, `tx_full` and the pending address. A shorter SE0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | One-cycle strobe: a packet has ended |
| pkt_pid | input | 8 | PID byte of the received packet |
| pkt_addr | input | 8 | Byte after the PID (address in its low 7 bits) |
| pkt_len | input | LEN_W | Received length in bytes, PID and CRC included |
| se0 | input | 1 | Line is in single-ended-zero state |
| rx_release | input | 1 | Firmware has consumed the receive buffer |
| tx_load | input | 1 | Firmware has filled the transmit buffer |
| xfer_busy | input | 1 | A transfer still has packets to deliver |
| addr_set | input | 1 | Strobe to request a new device address |
| addr_new | input | 7 | Requested device address |
| reply_valid | output | 1 | Transmitter must start a reply |
| reply_kind | output | 2 | 1 ACK, 2 NAK, 3 data packet |
| reply_pid | output | 8 | Handshake PID to send, 0x00 for data |
| rx_sel | output | 1 | Receive buffer the receiver writes next |
| rx_full | output | 1 | Accepted data awaits firmware |
| rx_len | output | LEN_W | Length of the accepted data packet |
| rx_token | output | 8 | Token PID that preceded the accepted data |
| tx_full | output | 1 | Transmit buffer holds a packet |
| dev_addr | output | 7 | Active device address |
| bus_reset | output | 1 | One-cycle pulse on a detected bus reset |

## Verification
The assertions take for granted that `pkt_valid` is a single-cycle strobe, that `rx_release` is raised only after data has been accepted, and that `se0` never overlaps a packet strobe. The bench drives every packet as one isolated strobe with idle cycles between packets. It gives the release and load pulses only in idle cycles, except for the one case where R10 calls for a load in the same cycle as an IN. It holds SE0 only while the packet interface is idle. The checks therefore never depend on a reply being requested while another one is being registered.

// File: rtl/usbtk_pkg.sv
package usbtk_pkg;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;

  // Minimum length of a meaningful packet: PID plus two bytes
  localparam int MIN_PKT_BYTES = 3;

  typedef enum logic [1:0] {
    RPL_NONE = 2'd0,
    RPL_ACK  = 2'd1,
    RPL_NAK  = 2'd2,
    RPL_DATA = 2'd3
  } reply_e;

  typedef enum logic [2:0] {
    ACT_IDLE,    // no packet this cycle
    ACT_DROP,    // ignored: clears the stored token
    ACT_KEEP,    // store SETUP/OUT token
    ACT_TAKE,    // accept data, ACK
    ACT_REFUSE,  // NAK
    ACT_SEND     // answer IN with the buffered packet
  } action_e;

endpackage

// File: rtl/usbtk_rst_sync.sv
module usbtk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/usbtk_classify.sv
module usbtk_classify
  import usbtk_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             pkt_valid,
  input  logic [7:0]       pkt_pid,
  input  logic [7:0]       pkt_addr,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [6:0]       dev_addr,
  input  logic             tok_valid,
  input  logic             rx_full,
  input  logic             tx_full,
  output action_e          act
);

  logic is_data, is_short, addr_hit, is_token;

  assign is_data  = (pkt_pid == PID_DATA0) || (pkt_pid == PID_DATA1);
  assign is_token = (pkt_pid == PID_SETUP) || (pkt_pid == PID_OUT);
  assign is_short = pkt_len < LEN_W'(MIN_PKT_BYTES);
  assign addr_hit = pkt_addr[6:0] == dev_addr;

  // Data packets are resolved before the address comparison
  always_comb begin
    act = ACT_IDLE;
    if (pkt_valid) begin
      if (is_short)                 act = ACT_DROP;
      else if (is_data) begin
        if (!tok_valid)             act = ACT_DROP;
        else if (rx_full)           act = ACT_REFUSE;
        else                        act = ACT_TAKE;
      end
      else if (!addr_hit)           act = ACT_DROP;
      else if (pkt_pid == PID_IN) begin
        if (!tx_full || rx_full)    act = ACT_REFUSE;
        else                        act = ACT_SEND;
      end
      else if (is_token)            act = ACT_KEEP;
      else                          act = ACT_DROP;
    end
  end

endmodule

// File: rtl/usbtk_se0_det.sv
module usbtk_se0_det #(
  parameter int RUN = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic bus_rst
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_q, fire_d;

  always_comb begin
    if (!se0)                     cnt_d = '0;
    else if (cnt_q == CW'(RUN))   cnt_d = cnt_q;
    else                          cnt_d = cnt_q + 1'b1;
    fire_d = se0 && (cnt_q == CW'(RUN - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign bus_rst = fire_q;

  AST_RESET_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !bus_rst);                                     // R12
  AST_RESET_NEEDS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> $past(se0));                                   // R12

endmodule

// File: rtl/usbtk_addr_reg.sv
module usbtk_addr_reg #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_set,
  input  logic [AW-1:0] addr_new,
  input  logic          bus_rst,
  input  logic          tx_full,
  input  logic          xfer_busy,
  output logic [AW-1:0] dev_addr
);

  logic [AW-1:0] pend_q, pend_d, cur_q;
  logic          pend_en, cur_en;

  always_comb begin
    pend_en = bus_rst || addr_set;
    pend_d  = bus_rst ? '0 : addr_new;
    cur_en  = !tx_full && !xfer_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (cur_en)  cur_q  <= pend_q;
    end
  end

  assign dev_addr = cur_q;

  AST_ADDR_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full || xfer_busy) |=> $stable(dev_addr));             // R11

endmodule

// File: rtl/usbtk_ctrl.sv
module usbtk_ctrl
  import usbtk_pkg::*;
#(
  parameter int BUF_BYTES  = 11,
  parameter int SE0_CYCLES = 30,
  localparam int LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [7:0]       pkt_pid,
  input  logic [7:0]       pkt_addr,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             se0,
  input  logic             rx_release,
  input  logic             tx_load,
  input  logic             xfer_busy,
  input  logic             addr_set,
  input  logic [6:0]       addr_new,
  output logic             reply_valid,
  output logic [1:0]       reply_kind,
  output logic [7:0]       reply_pid,
  output logic             rx_sel,
  output logic             rx_full,
  output logic [LEN_W-1:0] rx_len,
  output logic [7:0]       rx_token,
  output logic             tx_full,
  output logic [6:0]       dev_addr,
  output logic             bus_reset
);

  logic    rst_s_n;
  logic    bus_rst;
  action_e act;

  logic             tokv_q, tokv_d;
  logic [7:0]       tok_q, tok_d;
  logic             rxf_q, rxf_d;
  logic             sel_q, sel_d;
  logic [LEN_W-1:0] rxlen_q, rxlen_d;
  logic [7:0]       rxtok_q, rxtok_d;
  logic             txf_q, txf_d;
  logic             rv_q, rv_d;
  reply_e           rk_q, rk_d;
  logic [7:0]       rp_q, rp_d;
  logic             take_en;

  usbtk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  usbtk_se0_det #(.RUN(SE0_CYCLES)) u_se0 (
    .clk(clk), .rst_n(rst_s_n), .se0(se0), .bus_rst(bus_rst)
  );

  usbtk_addr_reg #(.AW(7)) u_addr (
    .clk(clk), .rst_n(rst_s_n), .addr_set(addr_set), .addr_new(addr_new),
    .bus_rst(bus_rst), .tx_full(txf_q), .xfer_busy(xfer_busy),
    .dev_addr(dev_addr)
  );

  usbtk_classify #(.LEN_W(LEN_W)) u_cls (
    .pkt_valid(pkt_valid), .pkt_pid(pkt_pid), .pkt_addr(pkt_addr),
    .pkt_len(pkt_len), .dev_addr(dev_addr), .tok_valid(tokv_q),
    .rx_full(rxf_q), .tx_full(txf_q), .act(act)
  );

  // Next-state logic
  always_comb begin
    tokv_d  = tokv_q;
    tok_d   = tok_q;
    rxf_d   = rxf_q;
    sel_d   = sel_q;
    txf_d   = txf_q;
    rv_d    = 1'b0;
    rk_d    = RPL_NONE;
    rp_d    = 8'h00;
    take_en = 1'b0;

    if (rx_release) rxf_d = 1'b0;

    case (act)
      ACT_DROP: tokv_d = 1'b0;
      ACT_KEEP: begin
        tokv_d = 1'b1;
        tok_d  = pkt_pid;
      end
      ACT_TAKE: begin
        take_en = 1'b1;
        rxf_d   = 1'b1;
        sel_d   = ~sel_q;
        rv_d    = 1'b1;
        rk_d    = RPL_ACK;
        rp_d    = PID_ACK;
      end
      ACT_REFUSE: begin
        rv_d = 1'b1;
        rk_d = RPL_NAK;
        rp_d = PID_NAK;
      end
      ACT_SEND: begin
        txf_d = 1'b0;
        rv_d  = 1'b1;
        rk_d  = RPL_DATA;
      end
      default: ;
    endcase

    if (tx_load) txf_d = 1'b1;

    if (bus_rst) begin
      rxf_d = 1'b0;
      txf_d = 1'b0;
    end

    rxlen_d = pkt_len;
    rxtok_d = tok_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tokv_q  <= 1'b0;
      tok_q   <= 8'h00;
      rxf_q   <= 1'b0;
      sel_q   <= 1'b0;
      rxlen_q <= '0;
      rxtok_q <= 8'h00;
      txf_q   <= 1'b0;
      rv_q    <= 1'b0;
      rk_q    <= RPL_NONE;
      rp_q    <= 8'h00;
    end else begin
      tokv_q <= tokv_d;
      tok_q  <= tok_d;
      rxf_q  <= rxf_d;
      sel_q  <= sel_d;
      txf_q  <= txf_d;
      rv_q   <= rv_d;
      rk_q   <= rk_d;
      rp_q   <= rp_d;
      if (take_en) begin
        rxlen_q <= rxlen_d;
        rxtok_q <= rxtok_d;
      end
    end
  end

  assign reply_valid = rv_q;
  assign reply_kind  = rk_q;
  assign reply_pid   = rp_q;
  assign rx_sel      = sel_q;
  assign rx_full     = rxf_q;
  assign rx_len      = rxlen_q;
  assign rx_token    = rxtok_q;
  assign tx_full     = txf_q;
  assign bus_reset   = bus_rst;

  AST_REPLY_FOLLOWS_PKT: assert property (@(posedge clk) disable iff (!rst_s_n)
    reply_valid |-> $past(pkt_valid));                                      // R2
  AST_IN_NAK_WHEN_RX_PENDING: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pkt_valid && pkt_pid == PID_IN && pkt_len >= LEN_W'(MIN_PKT_BYTES)
     && pkt_addr[6:0] == dev_addr && rx_full)
    |=> (reply_valid && reply_kind == RPL_NAK));                            // R9
  AST_ACK_FILLS_RX: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reply_valid && reply_kind == RPL_ACK && !$past(bus_rst)) |-> rx_full); // R8
  AST_SEND_EMPTIES_TX: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reply_valid && reply_kind == RPL_DATA && !$past(tx_load)) |-> !tx_full); // R9
  AST_SEL_MOVES_ON_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_sel != $past(rx_sel)) |-> (reply_valid && reply_kind == RPL_ACK));  // R8
  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_reset |=> (!rx_full && !tx_full));                                  // R12

endmodule

// File: tb/usbtk_ctrl_test.sv
module usbtk_ctrl_test;
  import usbtk_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 11;
  localparam int SE0_RUN    = 12;
  localparam int LEN_W      = $clog2(BUF_BYTES + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pkt_valid = 1'b0;
  logic [7:0]       pkt_pid = 8'h00;
  logic [7:0]       pkt_addr = 8'h00;
  logic [LEN_W-1:0] pkt_len = '0;
  logic             se0 = 1'b0;
  logic             rx_release = 1'b0;
  logic             tx_load = 1'b0;
  logic             xfer_busy = 1'b0;
  logic             addr_set = 1'b0;
  logic [6:0]       addr_new = 7'h00;
  logic             reply_valid;
  logic [1:0]       reply_kind;
  logic [7:0]       reply_pid;
  logic             rx_sel, rx_full, tx_full, bus_reset;
  logic [LEN_W-1:0] rx_len;
  logic [7:0]       rx_token;
  logic [6:0]       dev_addr;

  int checks = 0;
  int failures = 0;
  int rst_pulses = 0;
  bit finished = 1'b0;

  typedef struct {
    reply_e kind;
    string  tag;
  } exp_t;
  exp_t expq[$];
  logic chk_next = 1'b0;

  usbtk_ctrl #(.BUF_BYTES(BUF_BYTES), .SE0_CYCLES(SE0_RUN)) uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_pid(pkt_pid),
    .pkt_addr(pkt_addr), .pkt_len(pkt_len), .se0(se0),
    .rx_release(rx_release), .tx_load(tx_load), .xfer_busy(xfer_busy),
    .addr_set(addr_set), .addr_new(addr_new), .reply_valid(reply_valid),
    .reply_kind(reply_kind), .reply_pid(reply_pid), .rx_sel(rx_sel),
    .rx_full(rx_full), .rx_len(rx_len), .rx_token(rx_token),
    .tx_full(tx_full), .dev_addr(dev_addr), .bus_reset(bus_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: a packet strobe seen at an edge is answered at the next negedge
  always @(posedge clk) chk_next <= pkt_valid;

  always @(negedge clk) begin
    if (bus_reset) rst_pulses++;
    if (chk_next) begin
      exp_t e;
      logic [7:0] epid;
      if (expq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 actual=queue-empty expected=item");
      end else begin
        e = expq.pop_front();
        epid = (e.kind == RPL_ACK) ? 8'hD2 : (e.kind == RPL_NAK) ? 8'h5A : 8'h00;
        checks++;
        if (reply_valid != (e.kind != RPL_NONE) ||
            (e.kind != RPL_NONE && (reply_kind != e.kind || reply_pid != epid))) begin
          failures++;
          $display("FAIL R2/%s actual=v%0d k%0d p0x%0h expected=v%0d k%0d p0x%0h",
                   e.tag, reply_valid, reply_kind, reply_pid,
                   (e.kind != RPL_NONE), e.kind, epid);
        end
      end
    end else if (reply_valid) begin
      checks++; failures++;
      $display("FAIL R2 actual=unexpected-reply expected=none");
    end
  end

  task automatic send(input logic [7:0] pid, input logic [7:0] ab, input int len,
                      input reply_e exp, input string tag, input logic load);
    exp_t e;
    @(negedge clk);
    pkt_valid = 1'b1; pkt_pid = pid; pkt_addr = ab; pkt_len = LEN_W'(len);
    tx_load = load;
    e.kind = exp; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    pkt_valid = 1'b0; tx_load = 1'b0;
  endtask

  task automatic pulse_release();
    @(negedge clk); rx_release = 1'b1; @(negedge clk); rx_release = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic request_addr(input logic [6:0] a);
    @(negedge clk); addr_set = 1'b1; addr_new = a;
    @(negedge clk); addr_set = 1'b0;
  endtask

  task automatic hold_se0(input int n);
    @(negedge clk); se0 = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    se0 = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 reply_valid", reply_valid, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 rx_sel", rx_sel, 0);
    chk("R1 dev_addr", dev_addr, 0);
    chk("R1 bus_reset", bus_reset, 0);

    // R9: IN with empty transmit buffer
    send(PID_IN, 8'h00, 3, RPL_NAK, "R9 in-empty", 1'b0);
    // R6: data with no token
    send(PID_DATA0, 8'h00, 5, RPL_NONE, "R6 no-token", 1'b0);
    chk("R6 rx_full", rx_full, 0);

    // R4 then R8: token stored, data accepted without address check
    send(PID_SETUP, 8'h00, 3, RPL_NONE, "R4 setup", 1'b0);
    send(PID_DATA0, 8'h7F, 11, RPL_ACK, "R8 accept", 1'b0);
    chk("R8 rx_full", rx_full, 1);
    chk("R8 rx_len", rx_len, 11);
    chk("R8 rx_token", rx_token, 8'h2D);
    chk("R8 rx_sel", rx_sel, 1);

    // R7: data while receive buffer full
    send(PID_OUT, 8'h00, 3, RPL_NONE, "R4 out", 1'b0);
    send(PID_DATA1, 8'h00, 4, RPL_NAK, "R7 full", 1'b0);
    chk("R7 rx_len", rx_len, 11);
    chk("R7 rx_token", rx_token, 8'h2D);
    chk("R7 rx_sel", rx_sel, 1);

    // R10 load, R9 NAK while rx pending
    pulse_load();
    chk("R10 tx_full set", tx_full, 1);
    send(PID_IN, 8'h00, 3, RPL_NAK, "R9 rx-pending", 1'b0);
    chk("R9 tx_full kept", tx_full, 1);
    pulse_release();
    chk("R10 rx_full cleared", rx_full, 0);
    send(PID_IN, 8'h00, 3, RPL_DATA, "R9 send", 1'b0);
    chk("R9 tx_full cleared", tx_full, 0);

    // R11: deferred address
    xfer_busy = 1'b1;
    request_addr(7'h15);
    repeat (3) @(negedge clk);
    chk("R11 busy holds", dev_addr, 0);
    pulse_load();
    xfer_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 tx_full holds", dev_addr, 0);
    send(PID_IN, 8'h00, 3, RPL_DATA, "R9 send2", 1'b0);
    repeat (2) @(negedge clk);
    chk("R11 applied", dev_addr, 7'h15);

    // R5: foreign address clears token; bit 7 of address byte not compared
    send(PID_SETUP, 8'h15, 3, RPL_NONE, "R4 setup-own", 1'b0);
    send(PID_SETUP, 8'h00, 3, RPL_NONE, "R5 foreign", 1'b0);
    send(PID_DATA0, 8'h00, 3, RPL_NONE, "R5 token-cleared", 1'b0);
    chk("R5 rx_full", rx_full, 0);
    chk("R5 rx_sel", rx_sel, 1);
    send(PID_OUT, 8'h95, 3, RPL_NONE, "R5 bit7", 1'b0);
    send(PID_DATA1, 8'h00, 3, RPL_ACK, "R5 bit7-accept", 1'b0);
    chk("R8 rx_token out", rx_token, 8'hE1);
    chk("R8 rx_sel toggle", rx_sel, 0);
    chk("R8 rx_len", rx_len, 3);

    // R5: other PID to own address clears token
    pulse_release();
    send(PID_OUT, 8'h15, 3, RPL_NONE, "R4 out-own", 1'b0);
    send(PID_ACK, 8'h15, 3, RPL_NONE, "R5 other-pid", 1'b0);
    send(PID_DATA0, 8'h15, 3, RPL_NONE, "R5 after-other", 1'b0);
    chk("R5 rx_full unchanged", rx_full, 0);

    // R3: short packet
    send(PID_OUT, 8'h15, 3, RPL_NONE, "R4 out-again", 1'b0);
    send(PID_DATA0, 8'h15, 2, RPL_NONE, "R3 short", 1'b0);
    send(PID_DATA0, 8'h15, 3, RPL_NONE, "R3 token-cleared", 1'b0);
    chk("R3 rx_full", rx_full, 0);

    // R10: load in the same cycle as a data reply
    pulse_load();
    send(PID_IN, 8'h15, 3, RPL_DATA, "R10 load-and-send", 1'b1);
    chk("R10 tx_full stays", tx_full, 1);

    // R12: bus reset
    send(PID_OUT, 8'h15, 3, RPL_NONE, "R4 out-r12", 1'b0);
    send(PID_DATA0, 8'h15, 6, RPL_ACK, "R8 accept-r12", 1'b0);
    request_addr(7'h22);
    hold_se0(SE0_RUN - 1);
    repeat (3) @(negedge clk);
    chk("R12 short se0 pulses", rst_pulses, 0);
    chk("R12 short se0 rx_full", rx_full, 1);
    chk("R12 short se0 tx_full", tx_full, 1);
    hold_se0(SE0_RUN);
    repeat (3) @(negedge clk);
    chk("R12 pulse count", rst_pulses, 1);
    chk("R12 rx_full", rx_full, 0);
    chk("R12 tx_full", tx_full, 0);
    repeat (2) @(negedge clk);
    chk("R12 pending cleared", dev_addr, 0);

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule